// File: doc/BRIEF.md
# Retriggerable Impulse Blanking Generator

This block watches the single-bit output of an impulse-noise comparator and drives a blanking gate. The gate quenches the IF signal path while an impulse is in progress, so clicks and pops do not reach the demodulator. The comparator bit may arrive from another clock domain, so it first passes through a two-stage synchronizer. Edge detection follows the synchronizer.

Every rising edge of the synchronized comparator starts a blanking interval. The interval has a minimum main part of `PULSE_CYCLES` clock cycles, which is 2 µs at the default 200 MHz clock. A separate hold part of `HOLD_CYCLES` cycles follows it and stretches the release of the gate. The assertion of the gate is never stretched. An edge that arrives during either part restarts the whole interval from its start, so a burst of impulses keeps the gate high until the burst has ended. A synchronous enable input switches the function off. While it is low, the gate stays low and no edge is remembered.

Top module: `nb_blank_top`

## Requirements
- R1: During reset and directly after reset, `blank_out` is 0.
- R2: When `cmp_in` goes from 0 to 1 and is first sampled high at clock edge k while `enable` is 1, `blank_out` is 1 directly after clock edge k+2.
- R3: After a single isolated rising edge, `blank_out` stays 1 for exactly `PULSE_CYCLES + HOLD_CYCLES` consecutive cycles and then returns to 0.
- R4: A rising edge that arrives while the main part is running reloads the full count. The gate then stays 1 without a gap until `PULSE_CYCLES + HOLD_CYCLES` cycles after the last edge.
- R5: A rising edge that arrives during the hold part keeps the gate at 1 with no dropout and restarts the full interval. The main and hold parts never run at the same time.
- R6: Only a 0-to-1 transition triggers the gate. A comparator level held high does not extend the gate beyond the interval started by its rising edge.
- R7: When `enable` is 0 at a clock edge, `blank_out` is 0 after that edge, even if an interval was running.
- R8: A rising edge that happens while `enable` is 0 is not stored. Raising `enable` while the comparator is held high produces no blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and clears every stage. |
| cmp_in | input | 1 | Impulse comparator output. It may be asynchronous to `clk`. |
| enable | input | 1 | Blanker on (1) or off (0). It must be synchronous to `clk`. |
| blank_out | output | 1 | Blanking gate. 1 means the IF path is quenched. |

## Verification
The assertions assume that `enable` is synchronous to `clk`. They also assume that a comparator level stays stable for at least one full clock period, so the synchronizer sees it. The bench changes both inputs only on the falling clock edge and never drives a comparator pulse shorter than one cycle. Under these conditions the edge the checker sees inside the block matches the one the reference model derives from its own sample history.

// File: rtl/nb_pkg.sv
package nb_pkg;

    // State of the comparator synchronizer and edge detector
    typedef struct packed {
        logic meta;   // first capture stage
        logic sync;   // second capture stage
        logic prev;   // synchronized value from the previous cycle
    } sync_state_t;

    // Derive a cycle count from a clock rate and a duration
    function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                                 input int unsigned dur_ns);
        return (clk_mhz * dur_ns) / 1000;
    endfunction

endpackage

// File: rtl/nb_sync_edge.sv
module nb_sync_edge
    import nb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o,
    output logic level_o
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A rising edge is a synchronized 1 that follows a synchronized 0
    assign rise_o  = st_q.sync & ~st_q.prev;
    assign level_o = st_q.sync;

endmodule

// File: rtl/nb_countdown.sv
module nb_countdown #(
    parameter int unsigned LOAD_VAL = 400,
    localparam int unsigned W = $clog2(LOAD_VAL + 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    output logic [W-1:0] cnt_o,
    output logic         busy_o,
    output logic         last_o
);

    localparam logic [W-1:0] LOAD_W = W'(LOAD_VAL);
    localparam logic [W-1:0] ONE_W  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = LOAD_W;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign busy_o = (st_q.cnt != '0);
    assign last_o = (st_q.cnt == ONE_W);

endmodule

// File: rtl/nb_blank_top.sv
module nb_blank_top
    import nb_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 200,
    parameter int unsigned PULSE_NS     = 2000,
    parameter int unsigned PULSE_CYCLES = ns_to_cycles(CLK_MHZ, PULSE_NS),
    parameter int unsigned HOLD_CYCLES  = 40,
    localparam int unsigned PW = $clog2(PULSE_CYCLES + 2),
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    input  logic enable,
    output logic blank_out
);

    logic          rise_w;
    logic          level_w;
    logic [PW-1:0] pulse_cnt_w;
    logic          pulse_busy_w;
    logic          pulse_last_w;
    logic [HW-1:0] hold_cnt_w;
    logic          hold_busy_w;
    logic          hold_last_w;

    logic pulse_clr, pulse_load, hold_clr, hold_load;

    nb_sync_edge i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .rise_o   (rise_w),
        .level_o  (level_w)
    );

    // The main part restarts on every accepted edge
    // The hold part starts when the main part runs out
    always_comb begin
        pulse_clr  = ~enable;
        pulse_load = enable & rise_w;
        hold_clr   = ~enable | rise_w;
        hold_load  = enable & pulse_last_w & ~rise_w;
    end

    nb_countdown #(.LOAD_VAL(PULSE_CYCLES)) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pulse_clr),
        .load   (pulse_load),
        .cnt_o  (pulse_cnt_w),
        .busy_o (pulse_busy_w),
        .last_o (pulse_last_w)
    );

    nb_countdown #(.LOAD_VAL(HOLD_CYCLES)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hold_clr),
        .load   (hold_load),
        .cnt_o  (hold_cnt_w),
        .busy_o (hold_busy_w),
        .last_o (hold_last_w)
    );

    assign blank_out = pulse_busy_w | hold_busy_w;

endmodule

// File: rtl/nb_blank_chk.sv
module nb_blank_chk #(
    parameter int unsigned PULSE_CYCLES = 400,
    parameter int unsigned PW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          blank_out,
    input logic          rise,
    input logic [PW-1:0] pulse_cnt,
    input logic          pulse_busy,
    input logic          hold_busy
);

    // R7
    disable_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !blank_out);

    // R2
    edge_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && enable) |=> blank_out);

    // R4
    edge_full_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && enable) |=> (pulse_cnt == PW'(PULSE_CYCLES)));

    // R5
    phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_busy && hold_busy));

    // R6
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_out) |-> $past(rise && enable));

    // R3
    release_not_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(blank_out) && $past(enable)) |-> !$past(rise));

endmodule

bind nb_blank_top nb_blank_chk #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .PW           (PW)
) i_nb_blank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .blank_out  (blank_out),
    .rise       (rise_w),
    .pulse_cnt  (pulse_cnt_w),
    .pulse_busy (pulse_busy_w),
    .hold_busy  (hold_busy_w)
);

// File: tb/test_nb_blank_top.sv
`timescale 1ns/1ps
module test_nb_blank_top;

    localparam int P = 6;
    localparam int H = 3;
    localparam int TOTAL = P + H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_in = 1'b0;
    logic enable = 1'b1;
    logic blank_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    int hist[4];
    int remaining = 0;
    logic exp_blank = 1'b0;

    always #2.5 clk = ~clk;

    nb_blank_top #(
        .PULSE_CYCLES (P),
        .HOLD_CYCLES  (H)
    ) i_nb_blank_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_in    (cmp_in),
        .enable    (enable),
        .blank_out (blank_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Behavioural model: a sample history and a cycles-left number
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) hist[i] = 0;
            remaining = 0;
        end else begin
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = int'(cmp_in);
            if (!enable) remaining = 0;
            else if (hist[2] == 1 && hist[3] == 0) remaining = TOTAL;
            else if (remaining > 0) remaining = remaining - 1;
        end
        exp_blank = (remaining > 0);
    end

    // Compare against the model on every cycle
    always @(negedge clk) begin
        cycles++;
        if (!done) check(tag, int'(blank_out), int'(exp_blank));
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one comparator pulse: hi cycles high, then lo cycles low
    task automatic burst(input int hi, input int lo);
        cmp_in = 1'b1;
        idle(hi);
        cmp_in = 1'b0;
        idle(lo);
    endtask

    // Count the cycles in a window during which the gate is high
    task automatic count_high(input int win, output int cnt);
        cnt = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (blank_out) cnt++;
        end
    endtask

    initial begin
        int cnt;
        int lat;
        // R1: reset state
        #1;
        check("R1", int'(blank_out), 0);
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1", int'(blank_out), 0);

        // R2: latency, first high at the third falling edge after the drive
        tag = "R2";
        @(negedge clk);
        cmp_in = 1'b1;
        lat = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            lat++;
            if (blank_out) break;
        end
        check("R2", lat, 3);
        cmp_in = 1'b0;
        idle(20);

        // R3: one isolated edge
        tag = "R3";
        cmp_in = 1'b1;
        idle(2);
        cmp_in = 1'b0;
        count_high(25, cnt);
        check("R3", cnt, TOTAL + 0);

        // R4: edges every four cycles during the main part
        tag = "R4";
        fork
            begin
                burst(2, 2);
                burst(2, 2);
                burst(2, 2);
            end
            count_high(40, cnt);
        join
        check("R4", cnt, 8 + TOTAL);

        // R5: second edge lands in the hold part
        tag = "R5";
        fork
            begin
                burst(1, 6);
                burst(1, 6);
            end
            count_high(40, cnt);
        join
        check("R5", cnt, 7 + TOTAL);

        // R6: level held high for a long time
        tag = "R6";
        fork
            burst(20, 5);
            count_high(35, cnt);
        join
        check("R6", cnt, TOTAL + 0);

        // R7: disable in the middle of an interval
        tag = "R7";
        cmp_in = 1'b1;
        idle(4);
        check("R7", int'(blank_out), 1);
        enable = 1'b0;
        idle(1);
        check("R7", int'(blank_out), 0);
        cmp_in = 1'b0;
        idle(4);
        enable = 1'b1;
        count_high(20, cnt);
        check("R7", cnt, 0);

        // R8: edge while disabled, then re-enable with the level still high
        tag = "R8";
        enable = 1'b0;
        idle(1);
        cmp_in = 1'b1;
        idle(6);
        enable = 1'b1;
        count_high(20, cnt);
        check("R8", cnt, 0);
        cmp_in = 1'b0;
        idle(5);
        // a fresh edge after re-enable still works
        fork
            burst(1, 4);
            count_high(25, cnt);
        join
        check("R8", cnt, TOTAL + 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule